// File: doc/BRIEF.md
# Two-Channel Timer Clock and Edge Front End

This block sits in front of a pair of timers. It picks the clock each timer counts and the edge of that clock that counts. A single 16-bit control word holds these settings for both channels, plus the edge rule for one external clear pin that both channels share. A free-running prescaler supplies seven divided versions of the base clock. One external clock pin can be routed to either channel in place of a divided clock. Each channel owns a 16-bit up-counter that advances on the chosen edge and returns to zero on the chosen clear edge.

Software loads the control word over a small write port. The port takes full words, single bytes under byte enables, and single-bit writes. The current word is always presented on a read port. The external clock and clear pins are asynchronous. Each is synchronized before any edge detection.

Top module: `tce_top`

## Requirements
- R1: After a synchronous reset the control word reads 0x0000 and both counters read 0. In this state both channels count falling edges of the base clock divided by 2, and clearing happens on falling edges of the clear pin.
- R2: A write with `wr_en` high loads `wr_data[7:0]` into bits 7:0 when `wr_be[0]` is set, and loads `wr_data[15:8]` into bits 15:8 when `wr_be[1]` is set. The new value is readable on `rd_data` after the next clock edge.
- R3: A cycle with `bit_we` high sets control bit `bit_idx` to `bit_val` and leaves every other bit unchanged. When a word write and a bit write occur in the same cycle, the bit write wins for its own bit.
- R4: Control bits 15:12 always read as 0. Writes to them, whether by word or by bit, are ignored.
- R5: Channel 0 takes its clock select from bits 2:0 and channel 1 from bits 5:3. Code k from 0 to 6 selects the base clock divided by 2^(k+1). Code 7 selects the external clock pin.
- R6: Channel 0 takes its count-edge mode from bits 9:8 and channel 1 from bits 11:10. The modes are: 00 counts falling edges, 01 counts rising edges, 11 counts both edges, and 10 stops counting.
- R7: Bits 7:6 set the clear-pin edge mode: 00 falling, 01 rising, 11 both, and 10 no clear. A clear edge sets both counters to 0.
- R8: When a clear edge and a count edge fall in the same cycle, the counter becomes 0.
- R9: The clock and clear pins each pass through a two-flop synchronizer. A pin change made between two clock edges shows on the counters after the third following rising edge of `clk`, and not before.
- R10: Each counter advances by at most 1 per cycle and wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word or byte write strobe |
| wr_be | input | 2 | Byte enables (bit 0 = low byte) |
| wr_data | input | 16 | Write data |
| bit_we | input | 1 | Single-bit write strobe |
| bit_idx | input | 4 | Bit index for a single-bit write |
| bit_val | input | 1 | Value for a single-bit write |
| rd_data | output | 16 | Current control word |
| ext_clk_pin | input | 1 | Asynchronous external count clock |
| ext_clr_pin | input | 1 | Asynchronous external clear input |
| cnt0 | output | 16 | Channel 0 counter |
| cnt1 | output | 16 | Channel 1 counter |

## Verification
The assertions assume that the pins are quiet apart from deliberate toggles. They also assume that any change of clock select is followed by a few settle cycles before counts are compared. This is because switching the selected waveform can produce one count edge. The stimulus therefore changes pins only on falling clock edges and waits four cycles after each configuration write. Count windows always span a whole number of periods of the selected divided clock. As a result, the expected increment does not depend on the prescaler phase.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam int REG_W     = 16;
  localparam int LIVE_W    = 12;
  localparam int SEL_W     = 3;
  localparam int MODE_W    = 2;
  localparam int NUM_CH    = 2;
  localparam int SEL_LSB   = 0;
  localparam int CLR_LSB   = 6;
  localparam int MODE_LSB  = 8;
  localparam int DIV_CODES = (1 << SEL_W) - 1;

  typedef enum logic [MODE_W-1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_OFF  = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  function automatic logic edge_hit(input logic [MODE_W-1:0] mode,
                                    input logic rise, input logic fall);
    unique case (mode)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tce_ctrl_reg.sv
module tce_ctrl_reg
  import tce_pkg::*;
#(
  parameter int W    = REG_W,
  parameter int LIVE = LIVE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [W/8-1:0]       wr_be,
  input  logic [W-1:0]         wr_data,
  input  logic                 bit_we,
  input  logic [$clog2(W)-1:0] bit_idx,
  input  logic                 bit_val,
  output logic [W-1:0]         ctrl_q
);
  localparam int NBYTE = W / 8;
  localparam logic [W-1:0] LIVE_MASK = W'((1 << LIVE) - 1);

  logic [W-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    for (int b = 0; b < NBYTE; b++) begin
      if (wr_en && wr_be[b]) ctrl_d[8*b +: 8] = wr_data[8*b +: 8];
    end
    if (bit_we) ctrl_d[bit_idx] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d & LIVE_MASK;
  end
endmodule

// File: rtl/tce_prescaler.sv
module tce_prescaler #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] pre_q
);
  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tce_pin_sync.sv
module tce_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= sync_q[STAGES-1];
  end

  assign level = sync_q[STAGES-1];
  assign rise  = level & ~hist_q;
  assign fall  = ~level & hist_q;
endmodule

// File: rtl/tce_channel.sv
module tce_channel
  import tce_pkg::*;
#(
  parameter int PW    = DIV_CODES,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PW-1:0]     pre_q,
  input  logic              ext_lvl,
  input  logic [SEL_W-1:0]  sel,
  input  logic [MODE_W-1:0] mode,
  input  logic              clr_hit,
  output logic [CNT_W-1:0]  cnt_q
);
  logic src, hist_q, rise, fall, step;

  always_comb begin
    if (sel == SEL_W'(DIV_CODES)) src = ext_lvl;
    else                          src = pre_q[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= src;
  end

  assign rise = src & ~hist_q;
  assign fall = ~src & hist_q;
  assign step = edge_hit(mode, rise, fall);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (clr_hit) cnt_q <= '0;
    else if (step)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tce_top.sv
module tce_top
  import tce_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [15:0]      wr_data,
  input  logic             bit_we,
  input  logic [3:0]       bit_idx,
  input  logic             bit_val,
  output logic [15:0]      rd_data,
  input  logic             ext_clk_pin,
  input  logic             ext_clr_pin,
  output logic [CNT_W-1:0] cnt0,
  output logic [CNT_W-1:0] cnt1
);
  logic [REG_W-1:0]     ctrl_q;
  logic [DIV_CODES-1:0] pre_q;
  logic                 ext_lvl, ext_rise_unused, ext_fall_unused;
  logic                 clr_lvl_unused, clr_rise, clr_fall, clr_hit;
  logic [CNT_W-1:0]     cnt_arr [NUM_CH];

  tce_ctrl_reg #(.W(REG_W), .LIVE(LIVE_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .bit_we(bit_we), .bit_idx(bit_idx), .bit_val(bit_val), .ctrl_q(ctrl_q)
  );

  tce_prescaler #(.PW(DIV_CODES)) u_pre (.clk(clk), .rst(rst), .pre_q(pre_q));

  tce_pin_sync #(.STAGES(SYNC)) u_ext_sync (
    .clk(clk), .rst(rst), .pin(ext_clk_pin),
    .level(ext_lvl), .rise(ext_rise_unused), .fall(ext_fall_unused)
  );

  tce_pin_sync #(.STAGES(SYNC)) u_clr_sync (
    .clk(clk), .rst(rst), .pin(ext_clr_pin),
    .level(clr_lvl_unused), .rise(clr_rise), .fall(clr_fall)
  );

  assign clr_hit = edge_hit(ctrl_q[CLR_LSB +: MODE_W], clr_rise, clr_fall);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tce_channel #(.PW(DIV_CODES), .CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst(rst), .pre_q(pre_q), .ext_lvl(ext_lvl),
        .sel(ctrl_q[SEL_LSB + SEL_W*c +: SEL_W]),
        .mode(ctrl_q[MODE_LSB + MODE_W*c +: MODE_W]),
        .clr_hit(clr_hit), .cnt_q(cnt_arr[c])
      );
    end
  endgenerate

  assign rd_data = ctrl_q;
  assign cnt0    = cnt_arr[0];
  assign cnt1    = cnt_arr[1];
endmodule

// File: rtl/tce_checker.sv
module tce_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] rd_data,
  input logic [15:0] cnt0,
  input logic [15:0] cnt1,
  input logic        clr_hit,
  input logic        wr_en,
  input logic [1:0]  wr_be,
  input logic [15:0] wr_data,
  input logic        bit_we
);
  // R6
  halted_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[9:8] == 2'b10 && !clr_hit) |=> $stable(cnt0));

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (cnt0 == 16'd0 && cnt1 == 16'd0));

  // R10
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> (cnt1 == $past(cnt1) || cnt1 == 16'($past(cnt1) + 16'd1)));

  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be == 2'b11 && !bit_we) |=> rd_data[11:0] == $past(wr_data[11:0]));
endmodule

bind tce_top tce_checker u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .cnt0(cnt0), .cnt1(cnt1),
  .clr_hit(clr_hit), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
  .bit_we(bit_we)
);

// File: tb/sim_tce_top.sv
module sim_tce_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic        wr_en = 0, bit_we = 0, bit_val = 0;
  logic [1:0]  wr_be = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  bit_idx = 0;
  logic        ext_clk_pin = 0, ext_clr_pin = 0;
  logic [15:0] rd_data, cnt0, cnt1;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  tce_top u0 (.*);

  // vector: {ch[3:0], sel[3:0], mode[3:0], periods[7:0], expected[11:0]}
  localparam logic [31:0] VEC [10] = '{
    {4'd0, 4'd0, 4'd1, 8'd20, 12'd20},
    {4'd0, 4'd0, 4'd0, 8'd20, 12'd20},
    {4'd0, 4'd0, 4'd3, 8'd20, 12'd40},
    {4'd0, 4'd3, 4'd1, 8'd5,  12'd5},
    {4'd0, 4'd6, 4'd3, 8'd2,  12'd4},
    {4'd1, 4'd1, 4'd0, 8'd10, 12'd10},
    {4'd1, 4'd2, 4'd3, 8'd6,  12'd12},
    {4'd1, 4'd5, 4'd1, 8'd3,  12'd3},
    {4'd0, 4'd2, 4'd2, 8'd10, 12'd0},
    {4'd1, 4'd0, 4'd2, 8'd10, 12'd0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_word(input logic [15:0] d, input logic [1:0] be);
    @(negedge clk); wr_en = 1; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 0; wr_be = 0;
  endtask

  task automatic wr_bit(input int idx, input logic v);
    @(negedge clk); bit_we = 1; bit_idx = 4'(idx); bit_val = v;
    @(negedge clk); bit_we = 0;
  endtask

  task automatic cfg(input logic [15:0] d);
    wr_word(d, 2'b11);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 ctrl", rd_data, 16'h0000);
    chk("R1 cnt0", cnt0, 16'h0000);
    chk("R1 cnt1", cnt1, 16'h0000);
    wait_neg(4);
    a = cnt0; wait_neg(20);
    chk("R1 default div2 falling", 16'(cnt0 - a), 16'd10);

    // R5 R6 table walk
    for (int i = 0; i < 10; i++) begin
      logic [15:0] w;
      logic [3:0] ch, sel, md;
      int per;
      {ch, sel, md} = VEC[i][31:20];
      per = int'(VEC[i][19:12]);
      w = 16'h0080;
      w[3*ch +: 3] = sel[2:0];
      w[8 + 2*ch +: 2] = md[1:0];
      cfg(w);
      a = (ch == 0) ? cnt0 : cnt1;
      wait_neg(per * (2 << sel));
      b = (ch == 0) ? cnt0 : cnt1;
      chk($sformatf("R5 R6 vector %0d", i), 16'(b - a), {4'd0, VEC[i][11:0]});
    end

    // R2 R4 byte writes
    wr_word(16'h0000, 2'b11);
    wr_word(16'hFFFF, 2'b01); chk("R2 low byte", rd_data, 16'h00FF);
    wr_word(16'hFFFF, 2'b10); chk("R4 high byte upper ignored", rd_data, 16'h0FFF);
    wr_word(16'h0000, 2'b11); chk("R2 word clear", rd_data, 16'h0000);
    // R3 R4 bit writes
    wr_bit(9, 1'b1);  chk("R3 set bit", rd_data, 16'h0200);
    wr_bit(14, 1'b1); chk("R4 bit write ignored", rd_data, 16'h0200);
    wr_bit(9, 1'b0);  chk("R3 clear bit", rd_data, 16'h0000);
    @(negedge clk); wr_en = 1; wr_be = 2'b11; wr_data = 16'h0003;
    bit_we = 1; bit_idx = 0; bit_val = 0;
    @(negedge clk); wr_en = 0; wr_be = 0; bit_we = 0;
    chk("R3 bit beats word", rd_data, 16'h0002);

    // R5 R9 external clock, rising
    cfg(16'h0187); a = cnt0;
    ext_clk_pin = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 no early count", cnt0, a);
    @(posedge clk); @(negedge clk);
    chk("R9 R5 ext count", cnt0, 16'(a + 1));
    ext_clk_pin = 0; wait_neg(6);
    chk("R6 falling ignored", cnt0, 16'(a + 1));
    cfg(16'h0387); a = cnt0;
    ext_clk_pin = 1; wait_neg(4);
    chk("R6 both rise", cnt0, 16'(a + 1));
    ext_clk_pin = 0; wait_neg(4);
    chk("R6 both fall", cnt0, 16'(a + 2));
    cfg(16'h0087); a = cnt0;
    ext_clk_pin = 1; wait_neg(4);
    chk("R6 rising ignored", cnt0, a);
    ext_clk_pin = 0; wait_neg(4);
    chk("R6 falling counted", cnt0, 16'(a + 1));

    // R7 R8 clear on falling edge while counting every cycle
    cfg(16'h0300); a = cnt0;
    ext_clr_pin = 1; wait_neg(4);
    chk("R7 rise no clear", cnt0, 16'(a + 4));
    ext_clr_pin = 0;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8 clear wins cnt0", cnt0, 16'h0000);
    chk("R7 clear cnt1", cnt1, 16'h0000);
    @(negedge clk);
    chk("R8 resumes", cnt0, 16'h0001);
    // R7 pass-through
    cfg(16'h0380); a = cnt0;
    ext_clr_pin = 1; wait_neg(4); ext_clr_pin = 0; wait_neg(4);
    chk("R7 pass-through", cnt0, 16'(a + 8));
    // R7 rising clear
    cfg(16'h0340);
    ext_clr_pin = 1;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 rising clear", cnt0, 16'h0000);
    ext_clr_pin = 0;

    // R10 wrap
    cfg(16'h0380); a = cnt0;
    wait_neg(int'(16'hFFFF - a));
    chk("R10 reach max", cnt0, 16'hFFFF);
    @(negedge clk);
    chk("R10 wrap", cnt0, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule